// File: doc/BRIEF.md
# I2C interrupt and wait-timing controller

This block runs next to an I2C shift engine and decides, byte by byte, when software gets an interrupt and when the SCL line must be stretched low. It watches the bus lines through synchronisers. It finds start, repeated-start and stop conditions, and it numbers the SCL falling edges inside every byte. On the 8th falling edge it also compares the address byte it has collected against a programmable own address.

Two inputs set the context. One says whether the part is the bus master. The other is a timing-mode bit that places data-byte events at the 8th or the 9th falling edge. The address phase follows fixed rules, described in the requirements below. These rules cover a master, a matched slave, an extension code, and an address miss with or without a repeated start.

There are three outputs. The first is a one-clock interrupt pulse. The second is an SCL low-hold request that stays set until software pulses a release strobe. The third is a forced-ACK flag that marks the acknowledge slot of a matched slave address.

Top module: `i2c_irq_wait_ctrl`

## Requirements
- R1: After reset `irq`, `scl_hold` and `ack_force` are 0.
- R2: In the data phase with `late_mode`=0, `irq` pulses and `scl_hold` sets at the 8th SCL falling edge of each byte. This applies as master and as addressed slave.
- R3: In the data phase with `late_mode`=1, `irq` pulses and `scl_hold` sets at the 9th SCL falling edge of each byte.
- R4: As master (`is_master`=1), the address byte gives `irq` and `scl_hold` at its 9th falling edge, whatever `late_mode` is.
- R5: As slave, if bits [7:1] of the address byte equal `own_addr`, `irq` and `scl_hold` come at the 9th falling edge, whatever `late_mode` is. Bits arrive MSB first and are sampled on SCL rising edges. `ack_force` is 1 from the 8th to the 9th falling edge of that byte.
- R6: As slave, an address byte that does not match and has bits [7:3] = 11110 is an extension code. It gives `irq` and `scl_hold` at the 8th falling edge and nothing at the 9th. Later bytes are treated as data.
- R7: As slave, an address miss after a repeated start (a start seen without an intervening stop) gives an `irq` pulse at the 9th falling edge but no `scl_hold`.
- R8: As slave, an address miss after a first start that is not an extension code gives no `irq`, no `scl_hold` and no `ack_force` for the rest of the transfer.
- R9: `irq` is high for exactly one clock per event. `scl_hold` stays 1 until a clock in which `release_stb` is 1, and it drops after that clock. A `release_stb` while `scl_hold` is 0 has no effect.
- R10: An SCL falling edge present at `scl_in` at clock edge k shows on the outputs right after clock edge k+3.
- R11: A start, a repeated start or a stop resets the falling-edge count of the byte. The first SCL fall after a start is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| is_master | input | 1 | 1 = part acts as master, 0 = slave |
| late_mode | input | 1 | 0 = data events at the 8th fall, 1 = at the 9th |
| own_addr | input | 7 | Slave address compared with address bits [7:1] |
| release_stb | input | 1 | One-clock strobe ending a wait |
| irq | output | 1 | One-clock interrupt request pulse |
| scl_hold | output | 1 | Request to hold SCL low (wait) |
| ack_force | output | 1 | ACK is driven for a matched slave address |

## Verification
The hardest state to reach from the ports is a slave address miss right after a repeated start. The bench gets there in one transfer. It is first addressed correctly, takes a data byte, issues a repeated start with SCL low, and then sends a foreign address. An earlier transfer sends a foreign address after a plain start, so the silent case and the interrupt-only case can be told apart. A byte cut off after four bits by a repeated start checks that the edge count restarts. If it did not restart, an interrupt would appear at the wrong edge of the next byte.

// File: rtl/i2c_iw_pkg.sv
package i2c_iw_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    AK_NONE  = 2'd0,
    AK_MATCH = 2'd1,
    AK_EXT   = 2'd2
  } akind_t;

  localparam int          EXT_W      = 5;
  localparam logic [4:0]  EXT_PREFIX = 5'b11110;
endpackage

// File: rtl/iw_sync.sv
module iw_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/iw_bus_events.sv
module iw_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_p,
  output logic stop_p,
  output logic fall_p,
  output logic rise_p,
  output logic sda_v
);
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d   <= 1'b1;
      sda_d   <= 1'b1;
      start_p <= 1'b0;
      stop_p  <= 1'b0;
      fall_p  <= 1'b0;
      rise_p  <= 1'b0;
      sda_v   <= 1'b1;
    end else begin
      scl_d   <= scl_s;
      sda_d   <= sda_s;
      start_p <= scl_d & scl_s & sda_d & ~sda_s;
      stop_p  <= scl_d & scl_s & ~sda_d & sda_s;
      fall_p  <= scl_d & ~scl_s;
      rise_p  <= ~scl_d & scl_s;
      sda_v   <= sda_s;
    end
  end
endmodule

// File: rtl/iw_byte_track.sv
module iw_byte_track
  import i2c_iw_pkg::*;
#(
  parameter int BYTE_BITS = 8,
  parameter int ADDR_W    = BYTE_BITS - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic              fall_p,
  input  logic              rise_p,
  input  logic              sda_v,
  input  logic              is_master,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              edge_byte,
  output logic              edge_ack,
  output logic              addr_match,
  output logic              ext_code,
  output logic              rs_flag,
  output phase_t            phase,
  output akind_t            akind
);
  localparam int CNT_W = $clog2(BYTE_BITS + 2);
  localparam logic [CNT_W-1:0] BYTE_EDGE = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] ACK_EDGE  = CNT_W'(BYTE_BITS + 1);

  logic [CNT_W-1:0]     cnt_q;
  logic [CNT_W-1:0]     edge_num;
  logic                 skip_q, busy_q, edge_ok;
  logic [BYTE_BITS-1:0] sh_q;

  assign edge_ok    = fall_p & ~skip_q & ~start_p & ~stop_p;
  assign edge_num   = cnt_q + 1'b1;
  assign edge_byte  = edge_ok && (edge_num == BYTE_EDGE);
  assign edge_ack   = edge_ok && (edge_num == ACK_EDGE);
  assign addr_match = (sh_q[BYTE_BITS-1 -: ADDR_W] == own_addr);
  assign ext_code   = (sh_q[BYTE_BITS-1 -: EXT_W] == EXT_PREFIX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      skip_q  <= 1'b0;
      busy_q  <= 1'b0;
      rs_flag <= 1'b0;
      phase   <= PH_IDLE;
      akind   <= AK_NONE;
      sh_q    <= '0;
    end else if (start_p) begin
      cnt_q   <= '0;
      skip_q  <= 1'b1;
      rs_flag <= busy_q;
      busy_q  <= 1'b1;
      phase   <= PH_ADDR;
      akind   <= AK_NONE;
    end else if (stop_p) begin
      cnt_q   <= '0;
      skip_q  <= 1'b0;
      rs_flag <= 1'b0;
      busy_q  <= 1'b0;
      phase   <= PH_IDLE;
      akind   <= AK_NONE;
    end else begin
      if (rise_p) sh_q <= {sh_q[BYTE_BITS-2:0], sda_v};
      if (fall_p) begin
        if (skip_q) begin
          skip_q <= 1'b0;
        end else if (edge_ack) begin
          cnt_q <= '0;
          if (phase == PH_ADDR)
            phase <= (is_master || akind != AK_NONE) ? PH_DATA : PH_IDLE;
        end else begin
          cnt_q <= edge_num;
        end
      end
      if (edge_byte && phase == PH_ADDR && !is_master) begin
        if (addr_match)    akind <= AK_MATCH;
        else if (ext_code) akind <= AK_EXT;
        else               akind <= AK_NONE;
      end
    end
  end

  // R11: a start leaves the byte count at zero
  a_r11_count_cleared: assert property (@(posedge clk) disable iff (rst)
    start_p |=> (cnt_q == '0));
endmodule

// File: rtl/iw_wait_ctrl.sv
module iw_wait_ctrl
  import i2c_iw_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start_p,
  input  logic   stop_p,
  input  logic   edge_byte,
  input  logic   edge_ack,
  input  logic   addr_match,
  input  logic   ext_code,
  input  logic   rs_flag,
  input  phase_t phase,
  input  akind_t akind,
  input  logic   is_master,
  input  logic   late_mode,
  input  logic   release_stb,
  output logic   irq,
  output logic   scl_hold,
  output logic   ack_force
);
  logic fire, stretch, ack_set, ack_clr;

  always_comb begin
    fire    = 1'b0;
    stretch = 1'b0;
    ack_set = 1'b0;
    ack_clr = start_p | stop_p | edge_ack;
    case (phase)
      PH_ADDR: begin
        if (is_master) begin
          if (edge_ack) begin
            fire    = 1'b1;
            stretch = 1'b1;
          end
        end else begin
          if (edge_byte) begin
            if (addr_match) begin
              ack_set = 1'b1;
            end else if (ext_code) begin
              fire    = 1'b1;
              stretch = 1'b1;
            end
          end
          if (edge_ack) begin
            if (akind == AK_MATCH) begin
              fire    = 1'b1;
              stretch = 1'b1;
            end else if (akind == AK_NONE && rs_flag) begin
              fire = 1'b1;
            end
          end
        end
      end
      PH_DATA: begin
        if (late_mode ? edge_ack : edge_byte) begin
          fire    = 1'b1;
          stretch = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq       <= 1'b0;
      scl_hold  <= 1'b0;
      ack_force <= 1'b0;
    end else begin
      irq <= fire;
      if (stretch)          scl_hold <= 1'b1;
      else if (release_stb) scl_hold <= 1'b0;
      if (ack_set)          ack_force <= 1'b1;
      else if (ack_clr)     ack_force <= 1'b0;
    end
  end

  // R9: interrupt request is a single-clock pulse
  a_r9_irq_one_cycle: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R9: the hold only ends after a release strobe
  a_r9_hold_needs_release: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_hold) |-> $past(release_stb));

  // R7: a wait never begins without an interrupt
  a_r7_hold_starts_with_irq: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_hold) |-> irq);

  // R5: forced ACK only within the address byte
  a_r5_ack_in_addr: assert property (@(posedge clk) disable iff (rst)
    ack_force |-> (phase == PH_ADDR));
endmodule

// File: rtl/i2c_irq_wait_ctrl.sv
module i2c_irq_wait_ctrl
  import i2c_iw_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_BITS   = 8,
  parameter int ADDR_W      = BYTE_BITS - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              is_master,
  input  logic              late_mode,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              release_stb,
  output logic              irq,
  output logic              scl_hold,
  output logic              ack_force
);
  logic [1:0] lines_s;
  logic start_p, stop_p, fall_p, rise_p, sda_v;
  logic edge_byte, edge_ack, addr_match, ext_code, rs_flag;
  phase_t phase;
  akind_t akind;

  iw_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst(rst), .d({scl_in, sda_in}), .q(lines_s)
  );

  iw_bus_events u_events (
    .clk(clk), .rst(rst), .scl_s(lines_s[1]), .sda_s(lines_s[0]),
    .start_p(start_p), .stop_p(stop_p), .fall_p(fall_p),
    .rise_p(rise_p), .sda_v(sda_v)
  );

  iw_byte_track #(.BYTE_BITS(BYTE_BITS), .ADDR_W(ADDR_W)) u_track (
    .clk(clk), .rst(rst), .start_p(start_p), .stop_p(stop_p),
    .fall_p(fall_p), .rise_p(rise_p), .sda_v(sda_v),
    .is_master(is_master), .own_addr(own_addr),
    .edge_byte(edge_byte), .edge_ack(edge_ack),
    .addr_match(addr_match), .ext_code(ext_code), .rs_flag(rs_flag),
    .phase(phase), .akind(akind)
  );

  iw_wait_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start_p(start_p), .stop_p(stop_p),
    .edge_byte(edge_byte), .edge_ack(edge_ack),
    .addr_match(addr_match), .ext_code(ext_code), .rs_flag(rs_flag),
    .phase(phase), .akind(akind), .is_master(is_master),
    .late_mode(late_mode), .release_stb(release_stb),
    .irq(irq), .scl_hold(scl_hold), .ack_force(ack_force)
  );
endmodule

// File: tb/tb_i2c_irq_wait_ctrl.sv
module tb_i2c_irq_wait_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_i = 1'b1, sda_i = 1'b1;
  logic is_master = 1'b1, late_mode = 1'b0, release_stb = 1'b0;
  logic [6:0] own_addr = 7'h3A;
  logic irq, scl_hold, ack_force;

  int checks = 0, errors = 0;
  int n_irq = 0, n_hold = 0;
  bit prev_hold = 1'b0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_irq_wait_ctrl dut (
    .clk(clk), .rst(rst), .scl_in(scl_i), .sda_in(sda_i),
    .is_master(is_master), .late_mode(late_mode), .own_addr(own_addr),
    .release_stb(release_stb), .irq(irq), .scl_hold(scl_hold),
    .ack_force(ack_force)
  );

  // behavioural reference model
  int  m_cnt, m_ph, m_kind;
  bit  m_skip, m_busy, m_rs, ps, pd;
  bit  [7:0] m_sh;
  bit  pf[3], pw[3], pas[3], pac[3];
  bit  e_irq, e_hold, e_ack;

  always @(posedge clk) begin
    bit cs, cd, st, sp, fa, ri, f, w, as, ac, mt, ex;
    if (rst) begin
      m_cnt = 0; m_ph = 0; m_kind = 0; m_skip = 0; m_busy = 0; m_rs = 0;
      ps = 1; pd = 1; m_sh = 0; e_irq = 0; e_hold = 0; e_ack = 0;
      for (int i = 0; i < 3; i++) begin pf[i] = 0; pw[i] = 0; pas[i] = 0; pac[i] = 0; end
    end else begin
      e_irq = pf[2];
      if (pw[2]) e_hold = 1; else if (release_stb) e_hold = 0;
      if (pas[2]) e_ack = 1; else if (pac[2]) e_ack = 0;
      cs = scl_i; cd = sda_i;
      st = ps & cs & pd & ~cd;
      sp = ps & cs & ~pd & cd;
      fa = ps & ~cs;
      ri = ~ps & cs;
      f = 0; w = 0; as = 0; ac = 0;
      if (st) begin
        m_rs = m_busy; m_busy = 1; m_ph = 1; m_cnt = 0; m_skip = 1; m_kind = 0; ac = 1;
      end else if (sp) begin
        m_busy = 0; m_rs = 0; m_ph = 0; m_cnt = 0; m_skip = 0; m_kind = 0; ac = 1;
      end else begin
        if (ri) m_sh = {m_sh[6:0], cd};
        if (fa) begin
          if (m_skip) m_skip = 0;
          else begin
            m_cnt++;
            if (m_cnt == 9) ac = 1;
            if (m_ph == 1) begin
              if (is_master) begin
                if (m_cnt == 9) begin f = 1; w = 1; m_ph = 2; end
              end else begin
                if (m_cnt == 8) begin
                  mt = (m_sh[7:1] == own_addr);
                  ex = (m_sh[7:3] == 5'b11110);
                  if (mt) begin m_kind = 1; as = 1; end
                  else if (ex) begin m_kind = 2; f = 1; w = 1; end
                  else m_kind = 0;
                end else if (m_cnt == 9) begin
                  if (m_kind == 1) begin f = 1; w = 1; end
                  else if (m_kind == 0 && m_rs) f = 1;
                  m_ph = (m_kind != 0) ? 2 : 0;
                end
              end
            end else if (m_ph == 2) begin
              if ((late_mode && m_cnt == 9) || (!late_mode && m_cnt == 8)) begin
                f = 1; w = 1;
              end
            end
            if (m_cnt == 9) m_cnt = 0;
          end
        end
      end
      pf[2] = pf[1]; pf[1] = pf[0]; pf[0] = f;
      pw[2] = pw[1]; pw[1] = pw[0]; pw[0] = w;
      pas[2] = pas[1]; pas[1] = pas[0]; pas[0] = as;
      pac[2] = pac[1]; pac[1] = pac[0]; pac[0] = ac;
      ps = cs; pd = cd;
    end
  end

  // per-cycle comparison against the model (R10 timing and current scenario)
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (irq !== e_irq || scl_hold !== e_hold || ack_force !== e_ack) begin
        errors++;
        $display("FAIL R10 %s cycle compare: got irq=%0b hold=%0b ack=%0b expected irq=%0b hold=%0b ack=%0b",
                 cur_req, irq, scl_hold, ack_force, e_irq, e_hold, e_ack);
      end
      if (irq === 1'b1) n_irq++;
      if (scl_hold === 1'b1 && !prev_hold) n_hold++;
      prev_hold = (scl_hold === 1'b1);
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic service(input int extra);
    step(5);
    if (scl_hold) begin
      step(extra);
      release_stb = 1'b1; step(1); release_stb = 1'b0; step(1);
    end
  endtask

  task automatic send_bit(input bit b);
    sda_i = b; step(HALF);
    scl_i = 1'b1; step(HALF);
    scl_i = 1'b0;
    service(2);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    send_bit(1'b0);
  endtask

  task automatic bus_start();
    sda_i = 1'b1; scl_i = 1'b1; step(HALF);
    sda_i = 1'b0; step(HALF);
    scl_i = 1'b0; step(HALF);
  endtask

  task automatic bus_rstart();
    sda_i = 1'b1; step(2);
    scl_i = 1'b1; step(HALF);
    sda_i = 1'b0; step(HALF);
    scl_i = 1'b0; step(HALF);
  endtask

  task automatic bus_stop();
    sda_i = 1'b0; step(2);
    scl_i = 1'b1; step(HALF);
    sda_i = 1'b1; step(HALF * 2);
  endtask

  task automatic begin_case(input string req);
    cur_req = req; n_irq = 0; n_hold = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(4);
    rst = 1'b0;
    step(3);
    // R1 reset state
    check("R1", "irq after reset", irq, 0);
    check("R1", "scl_hold after reset", scl_hold, 0);
    check("R1", "ack_force after reset", ack_force, 0);

    // R9: release with no hold pending has no effect
    begin_case("R9");
    release_stb = 1'b1; step(1); release_stb = 1'b0; step(3);
    check("R9", "hold after idle release", scl_hold, 0);

    // R4 + R2: master, early mode, address + two data bytes
    begin_case("R4");
    is_master = 1'b1; late_mode = 1'b0;
    bus_start();
    for (int i = 7; i >= 0; i--) send_bit(8'hA0 >> i);
    // ninth bit: check latency and long hold by hand (R10, R9)
    sda_i = 1'b0; step(HALF); scl_i = 1'b1; step(HALF); scl_i = 1'b0;
    step(3);
    check("R10", "irq two clocks after fall", irq, 0);
    step(1);
    check("R10", "irq three clocks after fall", irq, 1);
    step(1);
    check("R9", "irq one clock wide", irq, 0);
    step(10);
    check("R9", "hold kept without release", scl_hold, 1);
    release_stb = 1'b1; step(1); release_stb = 1'b0; step(1);
    check("R9", "hold dropped after release", scl_hold, 0);
    cur_req = "R2";
    send_byte(8'h5C);
    send_byte(8'h13);
    bus_stop();
    check("R2", "master early irq count", n_irq, 3);
    check("R2", "master early hold count", n_hold, 3);

    // R3 + R4: master, late mode
    begin_case("R3");
    late_mode = 1'b1;
    bus_start();
    send_byte(8'hA1);
    send_byte(8'hFF);
    send_byte(8'h00);
    bus_stop();
    check("R3", "master late irq count", n_irq, 3);
    check("R4", "master late hold count", n_hold, 3);

    // R5: slave match, late mode, ack window
    begin_case("R5");
    is_master = 1'b0; late_mode = 1'b1; own_addr = 7'h3A;
    bus_start();
    for (int i = 7; i >= 0; i--) send_bit(8'h74 >> i);
    check("R5", "no irq by 8th fall on match", n_irq, 0);
    check("R5", "ack_force after 8th fall", ack_force, 1);
    send_bit(1'b0);
    check("R5", "ack_force after 9th fall", ack_force, 0);
    check("R5", "irq at 9th fall on match", n_irq, 1);
    send_byte(8'h9E);
    bus_stop();
    check("R5", "slave match irq count", n_irq, 2);
    check("R5", "slave match hold count", n_hold, 2);

    // R6: extension code, early data mode
    begin_case("R6");
    late_mode = 1'b0;
    bus_start();
    for (int i = 7; i >= 0; i--) send_bit(8'hF2 >> i);
    check("R6", "irq at 8th fall on extension", n_irq, 1);
    send_bit(1'b0);
    check("R6", "nothing at 9th fall on extension", n_irq, 1);
    send_byte(8'h47);
    bus_stop();
    check("R6", "extension irq count", n_irq, 2);
    check("R6", "extension hold count", n_hold, 2);

    // R8: miss after a first start
    begin_case("R8");
    bus_start();
    send_byte(8'h20);
    send_byte(8'h55);
    send_byte(8'hAA);
    bus_stop();
    check("R8", "miss irq count", n_irq, 0);
    check("R8", "miss hold count", n_hold, 0);

    // R7: match, data, repeated start, miss
    begin_case("R7");
    bus_start();
    send_byte(8'h74);
    send_byte(8'h31);
    bus_rstart();
    send_byte(8'h20);
    check("R7", "irq after rstart miss", n_irq, 3);
    check("R7", "hold after rstart miss", n_hold, 2);
    send_byte(8'h66);
    bus_stop();
    check("R7", "rstart miss total irq", n_irq, 3);

    // R11: byte cut by repeated start restarts count
    begin_case("R11");
    is_master = 1'b1;
    bus_start();
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_rstart();
    for (int i = 7; i >= 0; i--) send_bit(8'hA4 >> i);
    check("R11", "no irq before 9th of new byte", n_irq, 0);
    send_bit(1'b0);
    check("R11", "irq at 9th of new byte", n_irq, 1);
    bus_stop();
    step(10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule